// File: doc/BRIEF.md
# TMR Fault Status Capture Register

This block holds the sticky fault record of a three-processor redundant subsystem. Single-cycle event pulses from outside logic set bits in a 32-bit status word:
- pairwise lockstep mismatches;
- pairwise fatal errors;
- a fatal voter error;
- a fatal uncorrectable ECC error;
- watchdog expiry;
- a recovery-performed marker.

The comparators, voter, ECC logic and watchdog that raise these events sit outside the block. Software reads the word at any time over a plain register bus.

A bus write erases the whole word in one step, whatever data it carries. The erase takes effect only when a separate key input, taken from a control register, equals the configured key value. Any other write changes nothing.

A small decoder watches the three stored mismatch bits. When exactly two are set, it names the processor common to both pairs as faulty and declares recovery possible. Every other pattern yields no identity and no recovery.

Top module: `tmr_fault_status`

## Requirements
- R1: After reset, every bit of `status_rd` is 0, `faulty_id` is 0 and `recovery_ok` is 0.
- R2: An event pulse sampled at a clock edge sets its status bit, visible after that edge. The bit positions are:
  - bit 21: watchdog expiry;
  - bit 20: fatal ECC error;
  - bit 19: fatal voter error;
  - bits 18/17/16: fatal pair 2-3 / 1-3 / 1-2 (`ev_fatal_pair[2]/[1]/[0]`);
  - bit 3: recovery performed;
  - bits 2/1/0: mismatch pair 2-3 / 1-3 / 1-2 (`ev_lock_mis[2]/[1]/[0]`).
- R3: Bits 31..22 and 15..4 of `status_rd` always read 0.
- R4: A set status bit stays set on every later edge until a keyed clear.
- R5: When `bus_wr` is high and `ctrl_key` equals `KEY_VALUE` at an edge, all status bits are 0 after that edge, provided no event arrives in the same cycle.
- R6: When `bus_wr` is high and `ctrl_key` differs from `KEY_VALUE`, the status word is unchanged, provided no event arrives.
- R7: An event arriving in the same cycle as a keyed clear is set after that edge; all other bits clear.
- R8: Stored mismatch patterns (bits 2..0) 011, 101 and 110 give `faulty_id` 1, 2 and 3 respectively, with `recovery_ok` = 1.
- R9: Mismatch patterns 000, 001, 010, 100 and 111 give `faulty_id` 0 and `recovery_ok` 0.
- R10: `faulty_id` and `recovery_ok` follow the stored bits combinationally, changing in the same cycle as `status_rd`. Mismatch bits raised by separate pulses accumulate into one decoded pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_lock_mis | input | 3 | Mismatch pulses: [0] pair 1-2, [1] pair 1-3, [2] pair 2-3 |
| ev_fatal_pair | input | 3 | Fatal pulses: [0] pair 1-2, [1] pair 1-3, [2] pair 2-3 |
| ev_fatal_voter | input | 1 | Fatal voter error pulse |
| ev_fatal_ecc | input | 1 | Fatal uncorrectable ECC error pulse |
| ev_wdog_exp | input | 1 | Watchdog expiry pulse |
| ev_recovery | input | 1 | Recovery performed pulse |
| bus_wr | input | 1 | Register write strobe |
| ctrl_key | input | KEY_W | Key field from the control register |
| status_rd | output | 32 | Status word as seen on a read |
| faulty_id | output | 2 | Decoded faulty processor, 0 = none |
| recovery_ok | output | 1 | Exactly one processor is identified |

## Verification
Each event input is pulsed alone from a cleared word, which shows that every source lands on its own bit and nowhere else. The decoder is driven with all eight mismatch patterns. This separates the three two-bit patterns that each name a distinct processor from the single-bit, all-bit and empty patterns, which must all yield no verdict. It also builds one pattern from two separate pulses.

Writes are tried with the wrong key, with the right key, and with the right key coinciding with a fresh event. This distinguishes a gated clear from an ungated one, and event priority from clear priority.

// File: rtl/tmr_fault_pkg.sv
package tmr_fault_pkg;
    localparam int REG_W     = 32;
    localparam int PAIR_N    = 3;
    // packed layout of the stored (non-reserved) bits
    localparam int LIVE_N    = 2 * PAIR_N + 4;
    localparam int L_REC     = PAIR_N;
    localparam int L_FP_LO   = PAIR_N + 1;
    localparam int L_VOTER   = 2 * PAIR_N + 1;
    localparam int L_ECC     = 2 * PAIR_N + 2;
    localparam int L_WDOG    = 2 * PAIR_N + 3;
    // positions in the visible word
    localparam int B_LM_LO   = 0;
    localparam int B_REC     = 3;
    localparam int B_FP_LO   = 16;
    localparam int B_VOTER   = 19;
    localparam int B_ECC     = 20;
    localparam int B_WDOG    = 21;

    typedef enum logic [1:0] {
        PROC_NONE = 2'd0,
        PROC_1    = 2'd1,
        PROC_2    = 2'd2,
        PROC_3    = 2'd3
    } proc_id_e;
endpackage

// File: rtl/tmr_sticky_bits.sv
module tmr_sticky_bits #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;      // a new event outranks a clear
            else if (clr)
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tmr_pair_decoder.sv
module tmr_pair_decoder
    import tmr_fault_pkg::*;
(
    input  logic [PAIR_N-1:0] mis,
    output logic [1:0]        proc_id,
    output logic              can_recover
);
    proc_id_e verdict;

    always_comb begin
        unique case (mis)
            3'b011:  verdict = PROC_1;   // pairs 1-2 and 1-3 share processor 1
            3'b101:  verdict = PROC_2;   // pairs 1-2 and 2-3 share processor 2
            3'b110:  verdict = PROC_3;   // pairs 1-3 and 2-3 share processor 3
            default: verdict = PROC_NONE;
        endcase
    end

    assign proc_id     = verdict;
    assign can_recover = (verdict != PROC_NONE);
endmodule

// File: rtl/tmr_fault_status.sv
module tmr_fault_status
    import tmr_fault_pkg::*;
#(
    parameter int             KEY_W     = 8,
    parameter logic [KEY_W-1:0] KEY_VALUE = 8'hA5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ev_lock_mis,
    input  logic [2:0]        ev_fatal_pair,
    input  logic              ev_fatal_voter,
    input  logic              ev_fatal_ecc,
    input  logic              ev_wdog_exp,
    input  logic              ev_recovery,
    input  logic              bus_wr,
    input  logic [KEY_W-1:0]  ctrl_key,
    output logic [31:0]       status_rd,
    output logic [1:0]        faulty_id,
    output logic              recovery_ok
);
    logic              clr_fire;
    logic [LIVE_N-1:0] live_set;
    logic [LIVE_N-1:0] live_q;

    assign clr_fire = bus_wr && (ctrl_key == KEY_VALUE);

    assign live_set = {ev_wdog_exp, ev_fatal_ecc, ev_fatal_voter,
                       ev_fatal_pair, ev_recovery, ev_lock_mis};

    tmr_sticky_bits #(.W(LIVE_N)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_fire),
        .set   (live_set),
        .q     (live_q)
    );

    always_comb begin
        status_rd = '0;
        status_rd[B_LM_LO +: PAIR_N] = live_q[PAIR_N-1:0];
        status_rd[B_REC]             = live_q[L_REC];
        status_rd[B_FP_LO +: PAIR_N] = live_q[L_FP_LO +: PAIR_N];
        status_rd[B_VOTER]           = live_q[L_VOTER];
        status_rd[B_ECC]             = live_q[L_ECC];
        status_rd[B_WDOG]            = live_q[L_WDOG];
    end

    tmr_pair_decoder u_dec (
        .mis         (live_q[PAIR_N-1:0]),
        .proc_id     (faulty_id),
        .can_recover (recovery_ok)
    );
endmodule

// File: rtl/tmr_fault_status_chk.sv
module tmr_fault_status_chk #(
    parameter int               KEY_W     = 8,
    parameter logic [KEY_W-1:0] KEY_VALUE = 8'hA5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       ev_lock_mis,
    input logic [2:0]       ev_fatal_pair,
    input logic             ev_fatal_voter,
    input logic             ev_fatal_ecc,
    input logic             ev_wdog_exp,
    input logic             ev_recovery,
    input logic             bus_wr,
    input logic [KEY_W-1:0] ctrl_key,
    input logic [31:0]      status_rd,
    input logic [1:0]       faulty_id,
    input logic             recovery_ok
);
    logic any_ev;
    logic key_hit;
    assign any_ev  = (|ev_lock_mis) || (|ev_fatal_pair) || ev_fatal_voter ||
                     ev_fatal_ecc || ev_wdog_exp || ev_recovery;
    assign key_hit = (ctrl_key == KEY_VALUE);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd[31:22] == '0) && (status_rd[15:4] == '0)); // R3

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && key_hit) |=> ((status_rd & $past(status_rd)) == $past(status_rd))); // R4

    AST_KEYED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && key_hit && !any_ev) |=> (status_rd == '0)); // R5

    AST_BAD_KEY_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !key_hit && !any_ev) |=> $stable(status_rd)); // R6

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdog_exp |=> status_rd[21]); // R7

    AST_VERDICT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_ok == ($countones(status_rd[2:0]) == 2)); // R8

    AST_ID_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_ok == (faulty_id != 2'd0)); // R9
endmodule

bind tmr_fault_status tmr_fault_status_chk #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ev_lock_mis    (ev_lock_mis),
    .ev_fatal_pair  (ev_fatal_pair),
    .ev_fatal_voter (ev_fatal_voter),
    .ev_fatal_ecc   (ev_fatal_ecc),
    .ev_wdog_exp    (ev_wdog_exp),
    .ev_recovery    (ev_recovery),
    .bus_wr         (bus_wr),
    .ctrl_key       (ctrl_key),
    .status_rd      (status_rd),
    .faulty_id      (faulty_id),
    .recovery_ok    (recovery_ok)
);

// File: tb/tmr_fault_status_bench.sv
`timescale 1ns/1ps
module tmr_fault_status_bench;
    localparam logic [7:0] KEY = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  ev_lock_mis = '0;
    logic [2:0]  ev_fatal_pair = '0;
    logic        ev_fatal_voter = 1'b0;
    logic        ev_fatal_ecc = 1'b0;
    logic        ev_wdog_exp = 1'b0;
    logic        ev_recovery = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  ctrl_key = '0;
    logic [31:0] status_rd;
    logic [1:0]  faulty_id;
    logic        recovery_ok;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tmr_fault_status #(.KEY_W(8), .KEY_VALUE(KEY)) u_tmr_fault_status (
        .clk(clk), .rst_n(rst_n), .ev_lock_mis(ev_lock_mis), .ev_fatal_pair(ev_fatal_pair),
        .ev_fatal_voter(ev_fatal_voter), .ev_fatal_ecc(ev_fatal_ecc), .ev_wdog_exp(ev_wdog_exp),
        .ev_recovery(ev_recovery), .bus_wr(bus_wr), .ctrl_key(ctrl_key),
        .status_rd(status_rd), .faulty_id(faulty_id), .recovery_ok(recovery_ok)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one cycle of stimulus applied at a falling edge; results visible at the next falling edge
    task automatic cycle(input logic [9:0] ev, input logic wr, input logic [7:0] key);
        @(negedge clk);
        {ev_wdog_exp, ev_fatal_ecc, ev_fatal_voter, ev_fatal_pair, ev_recovery, ev_lock_mis} = ev;
        bus_wr = wr; ctrl_key = key;
        @(negedge clk);
        {ev_wdog_exp, ev_fatal_ecc, ev_fatal_voter, ev_fatal_pair, ev_recovery, ev_lock_mis} = '0;
        bus_wr = 1'b0; ctrl_key = '0;
    endtask

    task automatic do_clear();
        cycle('0, 1'b1, KEY);
    endtask

    function automatic logic [1:0] want_id(input logic [2:0] p);
        case (p)
            3'b011: return 2'd1;
            3'b101: return 2'd2;
            3'b110: return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    task automatic t_reset();
        chk("R1 status", status_rd, 32'h0);
        chk("R1 id", {30'h0, faulty_id}, 32'h0);
        chk("R1 recovery_ok", {31'h0, recovery_ok}, 32'h0);
    endtask

    task automatic t_fields();
        int pos[10] = '{0, 1, 2, 3, 16, 17, 18, 19, 20, 21};
        for (int i = 0; i < 10; i++) begin
            do_clear();
            cycle(10'(1) << i, 1'b0, '0);
            chk($sformatf("R2 source %0d", i), status_rd, 32'h1 << pos[i]);
        end
        cycle('1, 1'b0, '0);
        chk("R3 reserved zero with all set", status_rd & 32'hFFC0_FFF0, 32'h0);
        chk("R2 all sources", status_rd, 32'h003F_000F);
    endtask

    task automatic t_sticky();
        do_clear();
        cycle(10'b10_0000_0000, 1'b0, '0);
        repeat (3) @(negedge clk);
        chk("R4 sticky watchdog", status_rd, 32'h0020_0000);
    endtask

    task automatic t_bad_key();
        do_clear();
        cycle(10'b01_1000_1000, 1'b0, '0);   // ecc, voter, recovery
        cycle('0, 1'b1, KEY ^ 8'h01);
        chk("R6 wrong key ignored", status_rd, 32'h0018_0008);
        cycle('0, 1'b1, 8'h00);
        chk("R6 zero key ignored", status_rd, 32'h0018_0008);
    endtask

    task automatic t_good_key();
        cycle(10'b00_0111_0111, 1'b0, '0);
        do_clear();
        chk("R5 keyed clear", status_rd, 32'h0);
        chk("R5 id after clear", {30'h0, faulty_id}, 32'h0);
    endtask

    task automatic t_race();
        cycle(10'b10_0000_0011, 1'b0, '0);
        cycle(10'b00_1000_0000, 1'b1, KEY);  // voter event with valid clear
        chk("R7 event beats clear", status_rd, 32'h0008_0000);
    endtask

    task automatic t_decode();
        for (int p = 0; p < 8; p++) begin
            do_clear();
            cycle({7'h0, 3'(p)}, 1'b0, '0);
            chk($sformatf("R10 pattern %0d stored", p), status_rd, 32'(p));
            chk($sformatf("%s id pattern %0d", (want_id(3'(p)) != 0) ? "R8" : "R9", p),
                {30'h0, faulty_id}, {30'h0, want_id(3'(p))});
            chk($sformatf("%s ok pattern %0d", (want_id(3'(p)) != 0) ? "R8" : "R9", p),
                {31'h0, recovery_ok}, {31'h0, (want_id(3'(p)) != 0)});
        end
        do_clear();
        cycle(10'b00_0000_0001, 1'b0, '0);
        chk("R9 single bit no id", {30'h0, faulty_id}, 32'h0);
        cycle(10'b00_0000_0010, 1'b0, '0);
        chk("R10 accumulated id", {30'h0, faulty_id}, 32'h1);
        chk("R10 accumulated ok", {31'h0, recovery_ok}, 32'h1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_sticky();
        t_bad_key();
        t_good_key();
        t_race();
        t_decode();
        summary();
        $finish;
    end
endmodule